// File: doc/BRIEF.md
# Decoded Mask ROM with Precharge-Style Read

A read-only memory whose contents are fixed when the design is elaborated. The array is organised as 64-word blocks. A read passes through three decode stages: a one-hot block select from the upper address bits, a one-hot word-line group from address bits 5..3, and an eight-way bit-line multiplexer from address bits 2..0. Each block drives eight bit lines per data bit, with wired-OR evaluation, and the multiplexer picks one of the eight.

The clock-phased precharge/evaluate behaviour is modelled synchronously. A rising clock edge with the ROM selected closes an evaluate phase. That edge captures the address, and the decoded word drives the output from then on. While the ROM is deselected the captured address is kept, so the output holds its last value.

The contents come from a computed table of 32-bit entries. Stored word i takes its low half from entry 2*i and its high half from entry 2*i+1. Even entry 2*i holds the value i and odd entry 2*i+1 holds the value 1024 - i.

Top module: `mask_rom`

## Requirements
- R1: Legal configurations are a word count `NWORDS` of 64, 128, 256, 512 or 1024, with an address port of log2(`NWORDS`) bits, and a data width `WIDTH` that is a multiple of 4 from 4 to 64. Any other value stops elaboration with an error.
- R2: While `rst_ni` is low, and after reset until the first rising edge with `rom_sel_i` high, `data_o` is all zero.
- R3: At a rising edge with `rom_sel_i` high, `addr_i` is captured. From just after that edge, `data_o` shows the stored word at the captured address.
- R4: Stored word i has data bits 31..0 equal to table entry 2*i, which is i. For `WIDTH` above 32, data bits `WIDTH`-1..32 hold the low bits of table entry 2*i+1, which is 1024 - i.
- R5: For `WIDTH` of 32 or less, `data_o` is the low `WIDTH` bits of table entry 2*i only.
- R6: Address bits 6 and up select exactly one 64-word block, and at most one block is active at a time. With 64 words the single block is always selected. Reads on either side of each 64-word boundary return the right word.
- R7: Within a block, the word read is base + 8*k + l, where k = address bits 5..3 picks the word-line group and l = address bits 2..0 picks the bit-line multiplexer input. At most one group and at most one multiplexer line are active at a time.
- R8: At a rising edge with `rom_sel_i` low, the address is ignored and `data_o` keeps its value.
- R9: If the ROM is reselected in the same cycle that the address changes, the new address is read at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock. A selected rising edge ends an evaluate phase. |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rom_sel_i | input | 1 | ROM select. Gates capture and evaluation. |
| addr_i | input | log2(NWORDS) | Word address |
| data_o | output | WIDTH | Word read |

## Verification
Two functions can fall in the same cycle: the hold of the last word under deselection, and the capture of a new address. The bench provokes this by changing the address while deselected, checking that the output stays frozen, and then raising the select in the very cycle the address moves again. The edge after that must show the new word and not the held one. Four instances of different word counts and widths are swept over every address. Each result is judged against the word computed from the table rule, with particular attention to both sides of every 64-word boundary and the 32-bit split of the stored word.

// File: rtl/rom_pkg.sv
package rom_pkg;

  localparam int unsigned BLK_WORDS = 64;
  localparam int unsigned LINES     = 8;

  // 32-bit table entry e: even -> e/2, odd -> 1024 - e/2
  function automatic logic [31:0] table_entry(input int unsigned e);
    if (e % 2 == 0) return 32'(e / 2);
    else            return 32'(1024) - 32'(e / 2);
  endfunction

  function automatic logic [63:0] stored_word(input int unsigned idx);
    return {table_entry(2 * idx + 1), table_entry(2 * idx)};
  endfunction

  function automatic bit cfg_ok(input int unsigned nw, input int unsigned w);
    bit nw_ok;
    nw_ok = (nw == 64) || (nw == 128) || (nw == 256) || (nw == 512) || (nw == 1024);
    return nw_ok && (w % 4 == 0) && (w >= 4) && (w <= 64);
  endfunction

endpackage

// File: rtl/rom_predecode.sv
module rom_predecode (
  input  logic       en_i,
  input  logic [5:0] addr_i,
  output logic [7:0] wl_o,
  output logic [7:0] mux_o
);
  // selection lines built in pairs: 0/1, 2/3, 4/5, 6/7
  for (genvar p = 0; p < 4; p++) begin : g_pair
    assign wl_o[2*p]    = en_i && (addr_i[5:3] == 3'(2*p));
    assign wl_o[2*p+1]  = en_i && (addr_i[5:3] == 3'(2*p+1));
    assign mux_o[2*p]   = en_i && (addr_i[2:0] == 3'(2*p));
    assign mux_o[2*p+1] = en_i && (addr_i[2:0] == 3'(2*p+1));
  end
endmodule

// File: rtl/rom_blksel.sv
module rom_blksel #(
  parameter  int unsigned NWORDS = 128,
  localparam int unsigned AW     = $clog2(NWORDS),
  localparam int unsigned NBLK   = NWORDS / 64
) (
  input  logic          en_i,
  input  logic [AW-1:0] addr_i,
  output logic [NBLK-1:0] blk_o
);
  if (NBLK == 1) begin : g_single
    assign blk_o = en_i;  // one block: select tied active
  end else begin : g_multi
    localparam int unsigned BW = AW - 6;
    for (genvar b = 0; b < NBLK; b++) begin : g_blk
      assign blk_o[b] = en_i && (addr_i[AW-1:6] == BW'(b));
    end
  end
endmodule

// File: rtl/rom_block.sv
module rom_block #(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned BASE  = 0
) (
  input  logic             blk_en_i,
  input  logic [7:0]       wl_i,
  output logic [WIDTH-1:0] bl_o [8]
);
  logic [7:0] wl_g;
  assign wl_g = wl_i & {8{blk_en_i}};

  for (genvar l = 0; l < 8; l++) begin : g_line
    logic [WIDTH-1:0] terms [8];
    for (genvar k = 0; k < 8; k++) begin : g_grp
      localparam logic [WIDTH-1:0] CELL = WIDTH'(rom_pkg::stored_word(BASE + 8*k + l));
      assign terms[k] = wl_g[k] ? CELL : '0;
    end
    // wired-OR evaluation of the bit line
    always_comb begin
      bl_o[l] = '0;
      for (int k = 0; k < 8; k++) bl_o[l] = bl_o[l] | terms[k];
    end
  end
endmodule

// File: rtl/mask_rom.sv
module mask_rom #(
  parameter  int unsigned NWORDS = 128,
  parameter  int unsigned WIDTH  = 16,
  localparam int unsigned AW     = $clog2(NWORDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rom_sel_i,
  input  logic [AW-1:0]    addr_i,
  output logic [WIDTH-1:0] data_o
);
  localparam int unsigned NBLK = NWORDS / rom_pkg::BLK_WORDS;

  if (!rom_pkg::cfg_ok(NWORDS, WIDTH)) begin : g_bad_cfg
    $error("mask_rom: illegal NWORDS/WIDTH configuration");
  end

  logic [AW-1:0]   addr_q;
  logic            eval_q;
  logic [NBLK-1:0] blk_sel;
  logic [7:0]      wl_sel;
  logic [7:0]      mux_sel;
  logic [WIDTH-1:0] bl [NBLK][8];

  // selected edge closes the evaluate phase
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      eval_q <= 1'b0;
    end else if (rom_sel_i) begin
      addr_q <= addr_i;
      eval_q <= 1'b1;
    end
  end

  rom_blksel #(.NWORDS(NWORDS)) u_blksel (
    .en_i  (eval_q),
    .addr_i(addr_q),
    .blk_o (blk_sel)
  );

  rom_predecode u_predec (
    .en_i  (eval_q),
    .addr_i(addr_q[5:0]),
    .wl_o  (wl_sel),
    .mux_o (mux_sel)
  );

  for (genvar b = 0; b < NBLK; b++) begin : g_blk
    rom_block #(.WIDTH(WIDTH), .BASE(b * rom_pkg::BLK_WORDS)) u_blk (
      .blk_en_i(blk_sel[b]),
      .wl_i    (wl_sel),
      .bl_o    (bl[b])
    );
  end

  // eight-way bit-line mux, inactive blocks contribute zero
  always_comb begin
    data_o = '0;
    for (int b = 0; b < NBLK; b++)
      for (int l = 0; l < 8; l++)
        if (mux_sel[l]) data_o = data_o | bl[b][l];
  end
endmodule

// File: rtl/rom_chk.sv
module rom_chk #(
  parameter  int unsigned NWORDS = 128,
  parameter  int unsigned WIDTH  = 16,
  localparam int unsigned AW     = $clog2(NWORDS),
  localparam int unsigned NBLK   = NWORDS / 64,
  localparam int unsigned LW     = (WIDTH < 32) ? WIDTH : 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rom_sel_i,
  input logic [AW-1:0]    addr_i,
  input logic [WIDTH-1:0] data_o,
  input logic [NBLK-1:0]  blk_sel,
  input logic [7:0]       wl_sel,
  input logic [7:0]       mux_sel
);
  logic [AW-1:0] cap_addr;
  logic          cap_v;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_addr <= '0;
      cap_v    <= 1'b0;
    end else if (rom_sel_i) begin
      cap_addr <= addr_i;
      cap_v    <= 1'b1;
    end
  end

  assert_reset_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_v |-> data_o == '0);

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rom_sel_i |=> $stable(data_o));

  assert_low_half_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_v |-> data_o[LW-1:0] == LW'(cap_addr));

  if (WIDTH > 32) begin : g_hi
    assert_high_half_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cap_v |-> data_o[WIDTH-1:32] == (WIDTH-32)'(32'(1024) - 32'(cap_addr)));
  end

  assert_wl_onehot_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wl_sel));

  assert_mux_onehot_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(mux_sel));

  assert_blk_onehot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(blk_sel));
endmodule

bind mask_rom rom_chk #(.NWORDS(NWORDS), .WIDTH(WIDTH)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .rom_sel_i(rom_sel_i),
  .addr_i   (addr_i),
  .data_o   (data_o),
  .blk_sel  (blk_sel),
  .wl_sel   (wl_sel),
  .mux_sel  (mux_sel)
);

// File: tb/sim_mask_rom.sv
module sim_mask_rom;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel = 1'b0;
  logic [9:0] addr = '0;
  logic [15:0] d0;
  logic [63:0] d1;
  logic [35:0] d2;
  logic [3:0]  d3;
  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mask_rom #(.NWORDS(128), .WIDTH(16)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .rom_sel_i(sel), .addr_i(addr[6:0]), .data_o(d0));
  mask_rom #(.NWORDS(64), .WIDTH(64)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .rom_sel_i(sel), .addr_i(addr[5:0]), .data_o(d1));
  mask_rom #(.NWORDS(256), .WIDTH(36)) u2 (
    .clk_i(clk), .rst_ni(rst_n), .rom_sel_i(sel), .addr_i(addr[7:0]), .data_o(d2));
  mask_rom #(.NWORDS(1024), .WIDTH(4)) u3 (
    .clk_i(clk), .rst_ni(rst_n), .rom_sel_i(sel), .addr_i(addr[9:0]), .data_o(d3));

  function automatic logic [63:0] exp_word(int a, int w);
    logic [63:0] full;
    full = {32'(1024 - a), 32'(a)};
    return (w == 64) ? full : (full & ((64'd1 << w) - 64'd1));
  endfunction

  task automatic check(string tag, string inst, logic [63:0] got, logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s got=%h exp=%h", tag, inst, got, exp);
    end
  endtask

  task automatic check_all(int a, string tag);
    check(tag, "u0", 64'(d0), exp_word(a % 128, 16));
    check(tag, "u1", 64'(d1), exp_word(a % 64, 64));
    check(tag, "u2", 64'(d2), exp_word(a % 256, 36));
    check(tag, "u3", 64'(d3), exp_word(a % 1024, 4));
  endtask

  task automatic check_zero(string tag);
    check(tag, "u0", 64'(d0), 64'd0);
    check(tag, "u1", 64'(d1), 64'd0);
    check(tag, "u2", 64'(d2), 64'd0);
    check(tag, "u3", 64'(d3), 64'd0);
  endtask

  // drive at negedge, capture at posedge, sample at next negedge
  task automatic read(int a);
    sel  = 1'b1;
    addr = 10'(a);
    @(negedge clk);
  endtask

  task automatic t_config;
    check("R1", "u0", 64'($bits(d0)), 64'd16);
    check("R1", "u1", 64'($bits(d1)), 64'd64);
    check("R1", "u2", 64'($bits(d2)), 64'd36);
    check("R1", "u3", 64'($bits(d3)), 64'd4);
  endtask

  task automatic t_reset;
    check_zero("R2 in reset");
    @(negedge clk);
    rst_n = 1'b1;
    addr  = 10'd300;
    @(negedge clk);
    @(negedge clk);
    check_zero("R2 before first select");
  endtask

  task automatic t_sweep;
    for (int a = 0; a < 1024; a++) begin
      read(a);
      check_all(a, "R3 R4 R5");
    end
  endtask

  task automatic t_block_edges;
    int edges [12] = '{63, 64, 127, 128, 191, 192, 255, 256, 511, 512, 1023, 0};
    for (int i = 0; i < 12; i++) begin
      read(edges[i]);
      check_all(edges[i], "R6");
    end
  endtask

  task automatic t_lines;
    int pats [8] = '{7, 56, 42, 21, 63, 8, 1, 200};
    for (int i = 0; i < 8; i++) begin
      read(pats[i]);
      check_all(pats[i], "R7");
    end
  endtask

  task automatic t_hold_reselect;
    read(5);
    check_all(5, "R3");
    sel  = 1'b0;
    addr = 10'd77;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check_all(5, "R8");
      addr = 10'(900 + i);
    end
    read(77);
    check_all(77, "R9");
    sel  = 1'b0;
    addr = 10'd600;
    @(negedge clk);
    check_all(77, "R8");
    read(601);
    check_all(601, "R9");
  endtask

  task automatic t_midreset;
    read(333);
    check_all(333, "R3");
    rst_n = 1'b0;
    #1;
    check_zero("R2 async reset");
    @(negedge clk);
    rst_n = 1'b1;
    sel   = 1'b0;
    @(negedge clk);
    check_zero("R2 after reset");
    read(334);
    check_all(334, "R3");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_config();
    t_reset();
    t_sweep();
    t_block_edges();
    t_lines();
    t_hold_reselect();
    t_midreset();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule